// File: doc/BRIEF.md
# Serial 1001 Pattern Detector

This block watches a single serial data bit, sampled on every rising clock edge, and flags the arrival of the bit sequence 1, 0, 0, 1. It is a Moore machine. The flag comes only from the registered state, so it is free of glitches and stays high for exactly one clock cycle per hit.

The state sits in a three-bit register and uses plain binary codes: idle 000, then "1 seen" 001, "10 seen" 010, "100 seen" 011 and "match" 100. Matching does not overlap after a hit. From the match state, a 0 returns to idle and does not keep a partial "10". A 1 goes to the "1 seen" state. The codes 101, 110 and 111 are never used. If the register ever holds one of them, it returns to idle on the next edge whatever the data bit is.

An active-low asynchronous reset puts the machine back in idle at any time.

Top module: `pattern_det`

## Requirements
- R1: While rst_ni is low the state is idle (000) and detect_o is 0, and this takes effect at once, with no clock edge needed.
- R2: In idle (000), data 0 keeps the machine in idle and data 1 moves it to state 001.
- R3: In state 001, data 1 keeps the machine in 001 and data 0 moves it to 010.
- R4: In state 010, data 0 moves the machine to 011 and data 1 moves it back to 001.
- R5: In state 011, data 1 moves the machine to the match state 100 and data 0 moves it back to idle.
- R6: In the match state 100, data 0 moves the machine to idle and data 1 moves it to 001. So the stream 1001001 gives one hit and the stream 10011001 gives two.
- R7: detect_o is 1 exactly while the state is 100 and 0 in every other state. A hit therefore lasts one cycle and starts after the edge that samples the final 1.
- R8: The unused codes 101, 110 and 111 give detect_o = 0 and move to idle on the next rising edge whatever the data bit is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 1 | Serial data bit, sampled on each rising edge |
| detect_o | output | 1 | High for the cycle in which the state is the match state |

## Verification
Two things can happen on the same edge: leaving an unused code, and a data bit that would otherwise start or extend a match. The bench forces the register to 101, 110 or 111 while data is 1, then supplies 0, 0, 1. A design that treated the data bit as valid during recovery would reach the match state and raise detect_o. The correct design ends in "1 seen" and stays silent. The second case is a 1 arriving in the match state, which must both end the hit and start a new partial match. The 10011001 stream tests this: the behavioural model expects a second hit, and every cycle is compared against it.

// File: rtl/pattern_det_pkg.sv
package pattern_det_pkg;
  localparam int STATE_W = 3;
  typedef logic [STATE_W-1:0] state_t;
  localparam state_t ST_IDLE  = 3'd0;
  localparam state_t ST_ONE   = 3'd1;
  localparam state_t ST_ONE0  = 3'd2;
  localparam state_t ST_ONE00 = 3'd3;
  localparam state_t ST_MATCH = 3'd4;
endpackage

// File: rtl/pattern_det_next.sv
module pattern_det_next
  import pattern_det_pkg::*;
(
  input  state_t cur_i,
  input  logic   bit_i,
  output state_t nxt_o
);
  always_comb begin
    unique case (cur_i)
      ST_IDLE:  nxt_o = bit_i ? ST_ONE   : ST_IDLE;
      ST_ONE:   nxt_o = bit_i ? ST_ONE   : ST_ONE0;
      ST_ONE0:  nxt_o = bit_i ? ST_ONE   : ST_ONE00;
      ST_ONE00: nxt_o = bit_i ? ST_MATCH : ST_IDLE;
      ST_MATCH: nxt_o = bit_i ? ST_ONE   : ST_IDLE;
      default:  nxt_o = ST_IDLE; // unused codes recover
    endcase
  end
endmodule

// File: rtl/pattern_det_state.sv
module pattern_det_state
  import pattern_det_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  state_t nxt_i,
  output state_t cur_o
);
  state_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= nxt_i;
  end

  assign cur_o = state_q;
endmodule

// File: rtl/pattern_det_decode.sv
module pattern_det_decode
  import pattern_det_pkg::*;
(
  input  state_t cur_i,
  output logic   hit_o
);
  assign hit_o = (cur_i == ST_MATCH);
endmodule

// File: rtl/pattern_det.sv
module pattern_det
  import pattern_det_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic detect_o
);
  state_t cur_s;
  state_t nxt_s;

  pattern_det_next u_next (
    .cur_i (cur_s),
    .bit_i (data_i),
    .nxt_o (nxt_s)
  );

  pattern_det_state u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (nxt_s),
    .cur_o  (cur_s)
  );

  pattern_det_decode u_dec (
    .cur_i (cur_s),
    .hit_o (detect_o)
  );

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_s == ST_IDLE && !data_i) |=> (cur_s == ST_IDLE)); // R2
  AST_ONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_s == ST_ONE && data_i) |=> (cur_s == ST_ONE)); // R3
  AST_ONE0_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_s == ST_ONE0 && data_i) |=> (cur_s == ST_ONE)); // R4
  AST_ONE00_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_s == ST_ONE00 && !data_i) |=> (cur_s == ST_IDLE)); // R5
  AST_MATCH_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_s == ST_MATCH && !data_i) |=> (cur_s == ST_IDLE)); // R6
  AST_DETECT_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(detect_o) |-> $past(cur_s == ST_ONE00 && data_i)); // R7
  AST_DETECT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |=> !detect_o); // R7
  AST_ILLEGAL_RECOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_s > ST_MATCH) |=> (cur_s == ST_IDLE)); // R8
  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_s > ST_MATCH) |-> !detect_o); // R8
endmodule

// File: tb/tb_pattern_det.sv
`timescale 1ns/1ps
module tb_pattern_det;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic data_i = 1'b0;
  logic detect_o;

  int checks = 0;
  int failures = 0;
  int mst = 0;
  int hits = 0;

  always #2.5 clk_i = ~clk_i;

  pattern_det dut (.clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .detect_o(detect_o));

  function automatic int model_next(int s, logic b);
    case (s)
      0: return b ? 1 : 0;
      1: return b ? 1 : 2;
      2: return b ? 1 : 3;
      3: return b ? 4 : 0;
      4: return b ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s detect_o actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // drive one bit, clock it, compare with model just after the edge (R7 decode)
  task automatic step(logic b);
    int prev;
    data_i = b;
    @(posedge clk_i);
    prev = mst;
    mst = model_next(mst, b);
    #1;
    check(req_of(prev), detect_o, mst == 4);
    if (detect_o === 1'b1) hits++;
  endtask

  task automatic stream(string bits);
    for (int i = 0; i < bits.len(); i++) step(bits[i] == "1");
  endtask

  task automatic force_code(logic [2:0] code);
    @(negedge clk_i);
    force dut.u_state.state_q = code;
    #0.1;
    release dut.u_state.state_q;
    mst = int'(code);
    #0.1;
    check("R8", detect_o, 1'b0);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    check("R1", detect_o, 1'b0);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R6: non-overlapping after a hit
    hits = 0; stream("1001001");
    checks++; if (hits != 1) begin failures++; $display("FAIL R6 hits actual=%0d expected=1", hits); end
    stream("000");
    hits = 0; stream("10011001");
    checks++; if (hits != 2) begin failures++; $display("FAIL R6 hits actual=%0d expected=2", hits); end

    // R2..R5 paths
    stream("0000111101101010001000100");
    stream("11001");

    // R1: async reset while in match state
    stream("0001001");
    check("R7", detect_o, 1'b1);
    @(negedge clk_i); #1 rst_ni = 1'b0;
    #0.5 check("R1", detect_o, 1'b0);
    mst = 0;
    @(posedge clk_i); #1 rst_ni = 1'b1;
    check("R1", detect_o, 1'b0);

    // R8: recovery of each unused code with data 1 on the recovery edge
    for (int c = 5; c <= 7; c++) begin
      data_i = 1'b1;
      force_code(3'(c));
      step(1'b1);
      stream("001");
      check("R8", detect_o, 1'b0);
      stream("0001");
    end

    // pseudo-random stream against model
    begin
      logic [7:0] lfsr = 8'hA5;
      for (int i = 0; i < 400; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        step(lfsr[0] & (lfsr[2] | lfsr[5]) | (lfsr[0] & lfsr[1]));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule